// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block is the guard logic inside a serial flash slave. It oversamples the serial clock, data-in line and active-low chip select on a fast system clock. It assembles each chip-select framed instruction and, when chip select rises, decides whether the instruction takes effect. Data-modifying commands (page program, sector erase, block erase, chip erase, status write) go through every guard. The bit count must be a whole number of bytes and at least the command's minimum length. The write enable latch must be set. The power-up lockout must be over. The part must not be in deep power-down. The target must lie outside the read-only region.

An accepted program or erase produces a one-cycle execute strobe together with the target address, for use by the array sequencer that follows. A status write updates the protection bits inside the block. The status byte is always visible on an output port. The write-protect pin, together with the status write-disable bit, freezes the protection bits. Deep power-down makes the block deaf to everything except the release instruction.

Top module: `flash_wp_ctrl`

## Requirements
- R1: While reset is high and after it falls, the status output is 00h, no execute strobe is active and the block is not in deep power-down.
- R2: Opcode 06h (write enable) sets status bit 1 (write enable latch); opcode 04h (write disable) clears it.
- R3: A modifying command with a bit count that is not a multiple of eight, or shorter than its minimum, is rejected with the latch unchanged. The minimums are 40 bits for 02h, 32 for 20h and D8h, 8 for C7h and 16 for 01h.
- R4: A modifying command arriving with the write enable latch clear is rejected: no strobe, status unchanged.
- R5: For LOCK_CYC system clocks after reset falls, modifying commands are rejected with the latch kept, and write enable still works.
- R6: An accepted command pulses exactly one exec_o bit (bit0 page program 02h, bit1 sector erase 20h, bit2 block erase D8h, bit3 chip erase C7h) for one cycle. The pulse carries the address taken from frame bits 8 to 31, and the write enable latch clears.
- R7: With block-protect value BP (status bits 4:2) nonzero, the top 2^(BP-1) 64 KB blocks of the 512 KB array are read-only. Any value of 4 or more covers all blocks. Program or erase aimed there is rejected with the latch kept.
- R8: Chip erase is rejected when BP is nonzero and accepted when BP is zero.
- R9: An accepted status write (01h plus a data byte) loads BP from data bits 4:2 and the write-disable bit from data bit 7 (status bit 7), and clears the latch. Status bits 6:5 and bit 0 read zero.
- R10: While wp_n_i is low and status bit 7 is set, a status write is rejected and status bits 7:2 do not change.
- R11: Opcode B9h enters deep power-down. There every instruction other than ABh is ignored, with no strobe and no status change. ABh leaves deep power-down.
- R12: At most one exec_o bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset (power-up) |
| sclk_i | input | 1 | Serial clock, data sampled on its rising edge |
| sdi_i | input | 1 | Serial data in, MSB first |
| cs_n_i | input | 1 | Active-low chip select framing one instruction |
| wp_n_i | input | 1 | Active-low hardware write-protect pin |
| exec_o | output | 4 | One-hot execute strobes: program, sector, block, chip erase |
| exec_addr_o | output | ADDR_W | Target address for the strobed command |
| status_o | output | 8 | Status byte: bit7 write-disable, bits4:2 block protect, bit1 write enable latch |

## Verification
The bench builds the block with LOCK_CYC set to 600 and the default 19-bit address and 64 KB block size. A write enable followed by a full page program then fits inside the lockout window, and the same latch is spent right after the window closes. The eight-block array at these defaults lets block-protect values of 2 and 7 reach both a boundary block and the whole-array case. The serial clock runs at one eighth of the system clock, which leaves the synchronizers enough margin.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SERS = 8'h20;
  localparam logic [7:0] OP_BERS = 8'hD8;
  localparam logic [7:0] OP_CERS = 8'hC7;
  localparam logic [7:0] OP_DPD  = 8'hB9;
  localparam logic [7:0] OP_REL  = 8'hAB;

  localparam int EXEC_N  = 4;
  localparam int EX_PROG = 0;
  localparam int EX_SERS = 1;
  localparam int EX_BERS = 2;
  localparam int EX_CERS = 3;
endpackage

// File: rtl/flash_wp_frontend.sv
module flash_wp_frontend #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic             cs_n_i,
  output logic             frame_end_o,
  output logic [7:0]       op_o,
  output logic [7:0]       dat_o,
  output logic [23:0]      addr_o,
  output logic [CNT_W-1:0] nbits_o
);
  logic [1:0] sclk_sy, sdi_sy, cs_sy;
  logic       sclk_d, cs_d;
  logic [7:0] sh;
  logic [7:0] nxt;
  logic       rise, cs_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sy <= '0;
      sdi_sy  <= '0;
      cs_sy   <= 2'b11;
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[0], sclk_i};
      sdi_sy  <= {sdi_sy[0], sdi_i};
      cs_sy   <= {cs_sy[0], cs_n_i};
      sclk_d  <= sclk_sy[1];
      cs_d    <= cs_sy[1];
    end
  end

  assign rise        = sclk_sy[1] & ~sclk_d & ~cs_sy[1];
  assign cs_fall     = ~cs_sy[1] & cs_d;
  assign frame_end_o = cs_sy[1] & ~cs_d;
  assign nxt         = {sh[6:0], sdi_sy[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      nbits_o <= '0;
      op_o    <= '0;
      dat_o   <= '0;
      addr_o  <= '0;
    end else if (cs_fall) begin
      nbits_o <= '0;
    end else if (rise) begin
      sh <= nxt;
      if (nbits_o != '1) nbits_o <= nbits_o + 1'b1;
      if (nbits_o == CNT_W'(7))  op_o <= nxt;
      if (nbits_o == CNT_W'(15)) begin
        dat_o         <= nxt;
        addr_o[23:16] <= nxt;
      end
      if (nbits_o == CNT_W'(23)) addr_o[15:8] <= nxt;
      if (nbits_o == CNT_W'(31)) addr_o[7:0]  <= nxt;
    end
  end
endmodule

// File: rtl/flash_wp_lockout.sv
module flash_wp_lockout #(
  parameter int LOCK_CYC = 10000
) (
  input  logic clk,
  input  logic rst,
  output logic lock_o
);
  localparam int LW = $clog2(LOCK_CYC + 1);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      lock_o <= 1'b1;
    end else begin
      if (cnt != LW'(LOCK_CYC)) cnt <= cnt + 1'b1;
      lock_o <= (cnt != LW'(LOCK_CYC));
    end
  end
endmodule

// File: rtl/flash_wp_region.sv
module flash_wp_region #(
  parameter int ADDR_W    = 19,
  parameter int BLK_SHIFT = 16
) (
  input  logic [2:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;
  localparam int NBLK  = 1 << BLK_W;

  logic [BLK_W-1:0] blk;
  int unsigned      nprot;

  assign blk = addr_i[ADDR_W-1 -: BLK_W];

  always_comb begin
    nprot  = 32'd1 << (32'(bp_i) - 32'd1);
    prot_o = 1'b0;
    if (bp_i != 3'd0)
      prot_o = (32'(blk) + nprot) >= 32'(NBLK);
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int BLK_SHIFT = 16,
  parameter int LOCK_CYC  = 10000,
  parameter int CNT_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              cs_n_i,
  input  logic              wp_n_i,
  output logic [EXEC_N-1:0] exec_o,
  output logic [ADDR_W-1:0] exec_addr_o,
  output logic [7:0]        status_o
);
  logic             frame_end;
  logic [7:0]       op, dat;
  logic [23:0]      addr24;
  logic [CNT_W-1:0] nbits;
  logic             lock_w;
  logic             prot;
  logic             wel_q, srwd_q, dp_q;
  logic [2:0]       bp_q;
  logic             whole, hpm;

  flash_wp_frontend #(.CNT_W(CNT_W)) fe_i (
    .clk(clk_i), .rst(rst_i), .sclk_i(sclk_i), .sdi_i(sdi_i), .cs_n_i(cs_n_i),
    .frame_end_o(frame_end), .op_o(op), .dat_o(dat), .addr_o(addr24),
    .nbits_o(nbits)
  );

  flash_wp_lockout #(.LOCK_CYC(LOCK_CYC)) lk_i (
    .clk(clk_i), .rst(rst_i), .lock_o(lock_w)
  );

  flash_wp_region #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) rg_i (
    .bp_i(bp_q), .addr_i(addr24[ADDR_W-1:0]), .prot_o(prot)
  );

  assign whole = (nbits[2:0] == 3'd0) && wel_q && !lock_w;
  assign hpm   = !wp_n_i && srwd_q;

  function automatic logic long_enough(input logic [CNT_W-1:0] n, input int min);
    return 32'(n) >= min;
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wel_q       <= 1'b0;
      srwd_q      <= 1'b0;
      bp_q        <= '0;
      dp_q        <= 1'b0;
      exec_o      <= '0;
      exec_addr_o <= '0;
    end else begin
      exec_o <= '0;
      if (frame_end && long_enough(nbits, 8)) begin
        if (dp_q) begin
          if (op == OP_REL) dp_q <= 1'b0;
        end else begin
          case (op)
            OP_WREN: wel_q <= 1'b1;
            OP_WRDI: wel_q <= 1'b0;
            OP_DPD:  dp_q  <= 1'b1;
            OP_WRSR: if (whole && long_enough(nbits, 16) && !hpm) begin
              bp_q   <= dat[4:2];
              srwd_q <= dat[7];
              wel_q  <= 1'b0;
            end
            OP_PROG: if (whole && long_enough(nbits, 40) && !prot) begin
              exec_o[EX_PROG] <= 1'b1;
              exec_addr_o     <= addr24[ADDR_W-1:0];
              wel_q           <= 1'b0;
            end
            OP_SERS: if (whole && long_enough(nbits, 32) && !prot) begin
              exec_o[EX_SERS] <= 1'b1;
              exec_addr_o     <= addr24[ADDR_W-1:0];
              wel_q           <= 1'b0;
            end
            OP_BERS: if (whole && long_enough(nbits, 32) && !prot) begin
              exec_o[EX_BERS] <= 1'b1;
              exec_addr_o     <= addr24[ADDR_W-1:0];
              wel_q           <= 1'b0;
            end
            OP_CERS: if (whole && (bp_q == 3'd0)) begin
              exec_o[EX_CERS] <= 1'b1;
              exec_addr_o     <= '0;
              wel_q           <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign status_o = {srwd_q, 2'b00, bp_q, wel_q, 1'b0};
endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wp_n,
  input logic [3:0] exec,
  input logic [7:0] status,
  input logic       lock,
  input logic       dp
);
  a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(exec));

  a_r4_exec_needs_wel: assert property (@(posedge clk) disable iff (rst)
    (exec != 4'd0) |-> $past(status[1]));

  a_r5_no_exec_locked: assert property (@(posedge clk) disable iff (rst)
    (exec != 4'd0) |-> !$past(lock));

  a_r11_dp_no_exec: assert property (@(posedge clk) disable iff (rst)
    dp |=> (exec == 4'd0));

  a_r10_hpm_frozen: assert property (@(posedge clk) disable iff (rst)
    (!wp_n && status[7]) |=> $stable(status[7:2]));

  a_r8_ce_unprotected: assert property (@(posedge clk) disable iff (rst)
    exec[3] |-> ($past(status[4:2]) == 3'd0));
endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk chk_i (
  .clk(clk_i), .rst(rst_i), .wp_n(wp_n_i), .exec(exec_o),
  .status(status_o), .lock(lock_w), .dp(dp_q)
);

// File: tb/flash_wp_ctrl_tb_top.sv
module flash_wp_ctrl_tb_top;
  localparam int ADDR_W = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, wp_n = 1'b1;
  logic [3:0]        exec_o;
  logic [ADDR_W-1:0] exec_addr_o;
  logic [7:0]        status_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [22:0] expq[$];

  always #4 clk = ~clk;

  flash_wp_ctrl #(.ADDR_W(ADDR_W), .BLK_SHIFT(16), .LOCK_CYC(600), .CNT_W(12)) dut_i (
    .clk_i(clk), .rst_i(rst), .sclk_i(sclk), .sdi_i(sdi), .cs_n_i(cs_n),
    .wp_n_i(wp_n), .exec_o(exec_o), .exec_addr_o(exec_addr_o), .status_o(status_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [63:0] bits, input int n);
    cs_n = 1'b0;
    wait_clk(8);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic expect_exec(input logic [3:0] kind, input logic [ADDR_W-1:0] a);
    expq.push_back({kind, a});
  endtask

  task automatic st(input logic [7:0] exp, input string req);
    chk(status_o == exp, req, 32'(status_o), 32'(exp));
  endtask

  task automatic op8(input logic [7:0] op);
    frame(64'(op), 8);
  endtask

  task automatic prog(input logic [23:0] a);
    frame({24'd0, 8'h02, a, 8'hA5}, 40);
  endtask

  task automatic wrsr(input logic [7:0] d);
    frame({48'd0, 8'h01, d}, 16);
  endtask

  always @(negedge clk) begin
    if (!rst && exec_o != 4'd0) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R6 unexpected strobe", {9'd0, exec_o, exec_addr_o}, 32'd0);
      end else begin
        logic [22:0] e;
        e = expq.pop_front();
        chk({exec_o, exec_addr_o} == e, "R6/R12 strobe", {9'd0, exec_o, exec_addr_o}, {9'd0, e});
      end
    end
  end

  initial begin
    wait_clk(5);
    chk(status_o == 8'h00 && exec_o == 4'd0, "R1 in reset", {20'd0, exec_o, status_o}, 32'd0);
    rst = 1'b0;
    wait_clk(1);
    st(8'h00, "R1 after reset");

    // R5: write enable accepted during lockout, program rejected with latch kept
    op8(8'h06);
    st(8'h02, "R5 wren in lockout");
    prog(24'h000100);
    st(8'h02, "R5 program blocked in lockout");
    wait_clk(300);

    // R6: program after lockout
    expect_exec(4'b0001, 19'h12345);
    prog(24'h012345);
    st(8'h00, "R6 latch cleared by program");

    // R4: no latch
    prog(24'h000200);
    st(8'h00, "R4 program without latch");

    // R2
    op8(8'h06);
    st(8'h02, "R2 write enable");
    op8(8'h04);
    st(8'h00, "R2 write disable");

    // R3: bit counts
    op8(8'h06);
    frame({23'd0, 8'h02, 24'h000300, 8'hA5, 1'b1}, 41);
    st(8'h02, "R3 program 41 bits");
    frame({40'd0, 8'h20, 16'h0300}, 24);
    st(8'h02, "R3 sector erase 24 bits");
    frame({62'd0, 2'b11}, 2);
    st(8'h02, "R3 short junk frame");

    // R6: sector and block erase
    expect_exec(4'b0010, 19'h30000);
    frame({32'd0, 8'h20, 24'h030000}, 32);
    st(8'h00, "R6 sector erase clears latch");
    op8(8'h06);
    expect_exec(4'b0100, 19'h50000);
    frame({32'd0, 8'hD8, 24'h050000}, 32);
    st(8'h00, "R6 block erase clears latch");

    // R9: BP=2
    op8(8'h06);
    wrsr(8'h08);
    st(8'h08, "R9 status write bp=2");

    // R7 boundary
    op8(8'h06);
    prog(24'h070000);
    st(8'h0A, "R7 program top block rejected");
    expect_exec(4'b0001, 19'h5FFFF);
    prog(24'h05FFFF);
    st(8'h08, "R7 program below region accepted");
    op8(8'h06);
    frame({32'd0, 8'h20, 24'h060000}, 32);
    st(8'h0A, "R7 sector erase in region rejected");
    op8(8'hC7);
    st(8'h0A, "R8 chip erase rejected with bp");

    // R9: srwd and bp=7
    wrsr(8'h9C);
    st(8'h9C, "R9 status write srwd bp=7");
    op8(8'h06);
    prog(24'h000000);
    st(8'h9E, "R7 whole array protected");

    // R10
    wp_n = 1'b0;
    wait_clk(2);
    wrsr(8'h00);
    st(8'h9E, "R10 status write frozen");
    wp_n = 1'b1;
    wait_clk(2);
    wrsr(8'h00);
    st(8'h00, "R10 status write after pin release");

    // R8 accepted
    op8(8'h06);
    expect_exec(4'b1000, 19'h00000);
    op8(8'hC7);
    st(8'h00, "R8 chip erase accepted");

    // R11
    op8(8'h06);
    op8(8'hB9);
    op8(8'h04);
    st(8'h02, "R11 write disable ignored in power-down");
    prog(24'h001000);
    st(8'h02, "R11 program ignored in power-down");
    op8(8'hAB);
    op8(8'h04);
    st(8'h00, "R11 released");
    op8(8'h06);
    expect_exec(4'b0001, 19'h02000);
    prog(24'h002000);
    st(8'h00, "R11 program after release");

    wait_clk(20);
    chk(expq.size() == 0, "R6 all strobes seen", expq.size(), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule